// File: doc/BRIEF.md
# Dual-Issue In-Order Pairing Stage

This block sits between an instruction queue and two in-order execution pipes. Each cycle it looks at the two oldest instructions that have not yet issued. It sends the older one to pipe 0 and, when the two can travel together, the younger one to pipe 1. Instructions wait in an internal pending region. A stall at issue therefore never reaches the fetch side, and an instruction left behind by a single issue can pair with one that arrives in a later cycle.

A per-register countdown scoreboard predicts when each destination register will hold its result, using the latency carried in the instruction. A source whose countdown is not zero blocks issue. Pipes write back in order, so read-after-write is the only hazard checked. Issued instructions stay in a replay region of the same storage until a retire pulse removes the oldest one. A replay request discards all issued but unretired work: the next cycle restarts issue from the oldest unretired instruction, in program order, and all countdowns are cleared.

Top module: `dpair_top`

## Requirements
- R1: Instruction word layout (25 bits): src0 [3:0], src1 [7:4], dst [11:8], writes-register flag [12], latency [15:13], shared-resource flag [16], tag [24:17]. At most two issue per cycle. Pipe 1 issues only in a cycle where pipe 0 issues. Pipe 0 always carries the older instruction, and issue order equals acceptance order.
- R2: When the younger candidate reads the register that the older candidate writes, only the older one issues in that cycle.
- R3: When both candidates write the same register, only the older one issues.
- R4: When both candidates have the shared-resource flag set, only the older one issues.
- R5: A source written by an issued producer of latency L ≥ 1 may issue no earlier than L cycles after the producer (latency 0 acts as 1). While the pipe-0 candidate waits, nothing issues.
- R6: After a single issue, the leftover instruction pairs in pipe 0 with an instruction accepted in a later cycle, which goes to pipe 1.
- R7: An instruction accepted in a cycle can issue no earlier than the next cycle.
- R8: In a cycle with replay_req high, nothing issues. From the next cycle, issue restarts at the oldest unretired instruction and follows program order through the not-yet-issued ones.
- R9: A replay clears every countdown, so a source that was waiting becomes ready in the cycle after the replay.
- R10: A retire pulse removes the oldest issued, unretired instruction from the replay region. A retire pulse with nothing issued and unretired has no effect.
- R11: in_ready is high when at least two storage slots are free. While it is low, offered instructions are not taken.
- R12: After reset the storage is empty, nothing issues and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid0 | input | 1 | Older offered instruction is valid |
| in_instr0 | input | 25 | Older offered instruction word |
| in_valid1 | input | 1 | Younger offered instruction is valid (used only with in_valid0) |
| in_instr1 | input | 25 | Younger offered instruction word |
| in_ready | output | 1 | Both offered slots can be taken this cycle |
| iss0_valid | output | 1 | Pipe 0 issues this cycle |
| iss0_instr | output | 25 | Instruction sent to pipe 0 |
| iss1_valid | output | 1 | Pipe 1 issues this cycle |
| iss1_instr | output | 25 | Instruction sent to pipe 1 |
| retire_valid | input | 1 | Oldest issued instruction has written back |
| replay_req | input | 1 | Discard unretired issued work and reissue it |

## Verification
The hardest case to reach is a replay that must restart from the correct point after partial retirement. Reaching it needs issued work in flight, exactly some of it retired, surplus retire pulses already applied to an empty replay region, and a new arrival in the replay cycle. The stimulus builds this in a fixed order: it drains everything, sends spare retires, issues a pair, retires one, then replays while offering a new instruction. It then checks that the survivor and the newcomer pair up. A second sequence retires a long-latency producer and then replays, so that a waiting consumer shows the cleared countdown by issuing at once.

// File: rtl/dpair_pkg.sv
package dpair_pkg;
   localparam int REGW = 4;
   localparam int TAGW = 8;
   localparam int LATW = 3;

   typedef struct packed {
      logic [TAGW-1:0] tag;
      logic            shr;
      logic [LATW-1:0] lat;
      logic            wr;
      logic [REGW-1:0] dst;
      logic [REGW-1:0] src1;
      logic [REGW-1:0] src0;
   } dp_instr_t;

   localparam int INSTR_W = $bits(dp_instr_t);
endpackage

// File: rtl/dpair_buf.sv
// Ring store with three pointers: retire <= issue <= tail.
// [retire, issue) is the replay region, [issue, tail) the pending region.
module dpair_buf
   import dpair_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic [1:0] push_n,
   input  dp_instr_t push0,
   input  dp_instr_t push1,
   input  logic [1:0] pop_n,
   input  logic      retire,
   input  logic      replay,
   output dp_instr_t head0,
   output dp_instr_t head1,
   output logic      avail0,
   output logic      avail1,
   output logic      room
);
   localparam int PW = $clog2(DEPTH);

   dp_instr_t mem_q [DEPTH];
   logic [PW:0] ret_q, iss_q, tail_q, ret_nxt;
   logic [PW:0] pend, inflt, used;

   assign pend  = tail_q - iss_q;
   assign inflt = iss_q - ret_q;
   assign used  = tail_q - ret_q;

   assign avail0 = (pend != '0);
   assign avail1 = (pend > (PW+1)'(1));
   assign room   = (used <= (PW+1)'(DEPTH - 2));

   assign ret_nxt = ret_q + (PW+1)'((retire && inflt != '0) ? 1 : 0);

   assign head0 = mem_q[iss_q[PW-1:0]];
   assign head1 = mem_q[iss_q[PW-1:0] + PW'(1)];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ret_q  <= '0;
         iss_q  <= '0;
         tail_q <= '0;
      end else begin
         ret_q  <= ret_nxt;
         tail_q <= tail_q + (PW+1)'(push_n);
         iss_q  <= replay ? ret_nxt : iss_q + (PW+1)'(pop_n);
      end
   end

   always_ff @(posedge clk) begin
      if (push_n != 2'd0) mem_q[tail_q[PW-1:0]] <= push0;
      if (push_n == 2'd2) mem_q[tail_q[PW-1:0] + PW'(1)] <= push1;
   end
endmodule

// File: rtl/dpair_sb.sv
// Per-register countdown of cycles until the pending result is usable.
module dpair_sb
   import dpair_pkg::*;
#(
   parameter int NREG = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            set0_en,
   input  logic [REGW-1:0] set0_reg,
   input  logic [LATW-1:0] set0_cnt,
   input  logic            set1_en,
   input  logic [REGW-1:0] set1_reg,
   input  logic [LATW-1:0] set1_cnt,
   output logic [NREG-1:0] ready
);
   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic [LATW-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                                   cnt_q <= '0;
         else if (clear)                               cnt_q <= '0;
         else if (set0_en && set0_reg == REGW'(r))     cnt_q <= set0_cnt;
         else if (set1_en && set1_reg == REGW'(r))     cnt_q <= set1_cnt;
         else if (cnt_q != '0)                         cnt_q <= cnt_q - 1'b1;
      end
      assign ready[r] = (cnt_q == '0);
   end
endmodule

// File: rtl/dpair_pick.sv
// Decides how many of the two oldest pending instructions go out.
module dpair_pick
   import dpair_pkg::*;
#(
   parameter int NREG = 16
) (
   input  dp_instr_t       h0,
   input  dp_instr_t       h1,
   input  logic            av0,
   input  logic            av1,
   input  logic            replay,
   input  logic [NREG-1:0] rdy,
   output logic            go0,
   output logic            go1
);
   logic ok0, ok1, raw, waw, both_shr;

   always_comb begin
      ok0      = rdy[h0.src0] && rdy[h0.src1];
      ok1      = rdy[h1.src0] && rdy[h1.src1];
      raw      = h0.wr && (h1.src0 == h0.dst || h1.src1 == h0.dst);
      waw      = h0.wr && h1.wr && (h0.dst == h1.dst);
      both_shr = h0.shr && h1.shr;
      go0      = av0 && !replay && ok0;
      go1      = go0 && av1 && ok1 && !raw && !waw && !both_shr;
   end
endmodule

// File: rtl/dpair_top.sv
module dpair_top
   import dpair_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid0,
   input  logic [INSTR_W-1:0] in_instr0,
   input  logic               in_valid1,
   input  logic [INSTR_W-1:0] in_instr1,
   output logic               in_ready,
   output logic               iss0_valid,
   output logic [INSTR_W-1:0] iss0_instr,
   output logic               iss1_valid,
   output logic [INSTR_W-1:0] iss1_instr,
   input  logic               retire_valid,
   input  logic               replay_req
);
   localparam int NREG = 1 << REGW;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("dpair_top: DEPTH must be a power of two and at least 4");
   end

   function automatic logic [LATW-1:0] wait_of(input logic [LATW-1:0] l);
      return (l == '0) ? '0 : l - 1'b1;
   endfunction

   dp_instr_t       h0, h1;
   logic            av0, av1, room, go0, go1;
   logic [NREG-1:0] rdy;
   logic [1:0]      push_n, pop_n;

   assign push_n = (room && in_valid0) ? (in_valid1 ? 2'd2 : 2'd1) : 2'd0;
   assign pop_n  = {1'b0, go0} + {1'b0, go1};

   dpair_buf #(.DEPTH(DEPTH)) i_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_n (push_n),
      .push0  (dp_instr_t'(in_instr0)),
      .push1  (dp_instr_t'(in_instr1)),
      .pop_n  (pop_n),
      .retire (retire_valid),
      .replay (replay_req),
      .head0  (h0),
      .head1  (h1),
      .avail0 (av0),
      .avail1 (av1),
      .room   (room)
   );

   dpair_sb #(.NREG(NREG)) i_sb (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (replay_req),
      .set0_en  (go0 && h0.wr),
      .set0_reg (h0.dst),
      .set0_cnt (wait_of(h0.lat)),
      .set1_en  (go1 && h1.wr),
      .set1_reg (h1.dst),
      .set1_cnt (wait_of(h1.lat)),
      .ready    (rdy)
   );

   dpair_pick #(.NREG(NREG)) i_pick (
      .h0     (h0),
      .h1     (h1),
      .av0    (av0),
      .av1    (av1),
      .replay (replay_req),
      .rdy    (rdy),
      .go0    (go0),
      .go1    (go1)
   );

   assign in_ready   = room;
   assign iss0_valid = go0;
   assign iss0_instr = h0;
   assign iss1_valid = go1;
   assign iss1_instr = h1;
endmodule

// File: rtl/dpair_chk.sv
module dpair_chk
   import dpair_pkg::*;
(
   input logic               clk,
   input logic               rst_n,
   input logic               replay_req,
   input logic               iss0_valid,
   input logic [INSTR_W-1:0] iss0_instr,
   input logic               iss1_valid,
   input logic [INSTR_W-1:0] iss1_instr
);
   dp_instr_t c0, c1;
   assign c0 = iss0_instr;
   assign c1 = iss1_instr;

   a_r1_pipe1_needs_pipe0: assert property (@(posedge clk) disable iff (!rst_n)
      iss1_valid |-> iss0_valid);

   a_r2_no_pair_raw: assert property (@(posedge clk) disable iff (!rst_n)
      (iss1_valid && c0.wr) |-> (c1.src0 != c0.dst && c1.src1 != c0.dst));

   a_r3_no_pair_waw: assert property (@(posedge clk) disable iff (!rst_n)
      (iss1_valid && c0.wr && c1.wr) |-> (c1.dst != c0.dst));

   a_r4_no_pair_shared: assert property (@(posedge clk) disable iff (!rst_n)
      iss1_valid |-> !(c0.shr && c1.shr));

   a_r5_latency_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (iss0_valid && c0.wr && c0.lat >= LATW'(2)) |=>
      !(iss0_valid && (c0.src0 == $past(c0.dst) || c0.src1 == $past(c0.dst))));

   a_r8_quiet_on_replay: assert property (@(posedge clk) disable iff (!rst_n)
      replay_req |-> (!iss0_valid && !iss1_valid));
endmodule

bind dpair_top dpair_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .replay_req (replay_req),
   .iss0_valid (iss0_valid),
   .iss0_instr (iss0_instr),
   .iss1_valid (iss1_valid),
   .iss1_instr (iss1_instr)
);

// File: tb/test_dpair_top.sv
module test_dpair_top;
   localparam int PERIOD = 10;
   localparam int W = 25;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid0 = 1'b0, in_valid1 = 1'b0, retire_valid = 1'b0, replay_req = 1'b0;
   logic [W-1:0] in_instr0 = '0, in_instr1 = '0;
   logic in_ready, iss0_valid, iss1_valid;
   logic [W-1:0] iss0_instr, iss1_instr;

   int total = 0, bad = 0;
   bit done = 1'b0;
   logic [7:0] exp_q [$];
   logic s0v, s1v, srdy;
   logic [7:0] s0t, s1t;

   always #(PERIOD/2) clk = ~clk;

   dpair_top i_dpair_top (
      .clk(clk), .rst_n(rst_n),
      .in_valid0(in_valid0), .in_instr0(in_instr0),
      .in_valid1(in_valid1), .in_instr1(in_instr1),
      .in_ready(in_ready),
      .iss0_valid(iss0_valid), .iss0_instr(iss0_instr),
      .iss1_valid(iss1_valid), .iss1_instr(iss1_instr),
      .retire_valid(retire_valid), .replay_req(replay_req)
   );

   // tag, shared flag, latency, writes flag, dst, src1, src0
   function automatic logic [W-1:0] mk(input int tag, input bit shr, input int lat,
                                       input bit wr, input int dst, input int s1, input int s0);
      return {8'(tag), shr, 3'(lat), wr, 4'(dst), 4'(s1), 4'(s0)};
   endfunction

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One clock cycle: drive at the falling edge, sample just before the rising edge.
   task automatic cyc(input bit v0, input logic [W-1:0] a, input bit v1,
                      input logic [W-1:0] b, input bit rep, input bit ret);
      @(negedge clk);
      in_valid0 = v0; in_instr0 = a; in_valid1 = v1; in_instr1 = b;
      replay_req = rep; retire_valid = ret;
      #1;
      if (in_ready && v0) begin
         exp_q.push_back(a[24:17]);
         if (v1) exp_q.push_back(b[24:17]);
      end
      #3;
      s0v = iss0_valid; s0t = iss0_instr[24:17];
      s1v = iss1_valid; s1t = iss1_instr[24:17];
      srdy = in_ready;
   endtask

   task automatic idle();
      cyc(0, '0, 0, '0, 0, 0);
   endtask

   task automatic retire_n(input int n);
      for (int i = 0; i < n; i++) cyc(0, '0, 0, '0, 0, 1);
   endtask

   // Monitor: every issued tag must match the next expected one (R1 ordering).
   always @(negedge clk) begin
      #4;
      if (rst_n && !done) begin
         if (iss1_valid && !iss0_valid) check("R1 pipe1 alone", 1, 0);
         if (iss0_valid) begin
            if (exp_q.size() == 0) check("R1 unexpected pipe0 issue", int'(iss0_instr[24:17]), -1);
            else check("R1 pipe0 order", int'(iss0_instr[24:17]), int'(exp_q.pop_front()));
         end
         if (iss1_valid) begin
            if (exp_q.size() == 0) check("R1 unexpected pipe1 issue", int'(iss1_instr[24:17]), -1);
            else check("R1 pipe1 order", int'(iss1_instr[24:17]), int'(exp_q.pop_front()));
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(PERIOD * 5000);
      check("watchdog expired", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      check("R12 reset in_ready", srdy, 1);
      check("R12 reset iss0", s0v, 0);
      check("R12 reset iss1", s1v, 0);

      // independent pair
      cyc(1, mk(1,0,1,1,1,9,8), 1, mk(2,0,1,1,2,11,10), 0, 0);
      check("R7 no same-cycle issue", s0v, 0);
      idle();
      check("R1 pair pipe0 valid", s0v, 1); check("R1 pair pipe0 tag", s0t, 1);
      check("R1 pair pipe1 valid", s1v, 1); check("R1 pair pipe1 tag", s1t, 2);

      // read-after-write inside the pair, latency 1
      cyc(1, mk(3,0,1,1,3,9,8), 1, mk(4,0,1,0,0,10,3), 0, 0);
      idle();
      check("R2 older alone tag", s0t, 3); check("R2 younger held", s1v, 0);
      idle();
      check("R5 latency1 next cycle", s0v, 1); check("R5 latency1 tag", s0t, 4);

      // latency 3 producer
      cyc(1, mk(5,0,3,1,4,9,8), 1, mk(6,0,1,0,0,4,12), 0, 0);
      idle();
      check("R5 producer alone", s1v, 0);
      idle(); check("R5 wait cycle 1", s0v, 0);
      idle(); check("R5 wait cycle 2", s0v, 0);
      idle(); check("R5 consumer issues", s0v, 1); check("R5 consumer tag", s0t, 6);
      retire_n(6);

      // re-pairing across arrival cycles
      cyc(1, mk(7,0,1,1,5,9,8), 1, mk(8,0,1,0,0,10,5), 0, 0);
      cyc(1, mk(9,0,1,0,0,12,11), 1, mk(10,0,1,0,0,14,13), 0, 0);
      check("R6 first alone", s0t, 7); check("R6 first alone pipe1", s1v, 0);
      idle();
      check("R6 leftover pipe0", s0t, 8); check("R6 newcomer pipe1 valid", s1v, 1);
      check("R6 newcomer pipe1 tag", s1t, 9);
      idle();
      check("R6 tail alone", s0t, 10); check("R6 tail alone pipe1", s1v, 0);

      // blocked pipe0 blocks pipe1
      cyc(1, mk(11,0,4,1,6,9,8), 0, '0, 0, 0);
      cyc(1, mk(12,0,1,0,0,10,6), 1, mk(13,0,1,0,0,11,10), 0, 0);
      check("R5 latency4 producer", s0t, 11);
      idle(); check("R5 blocked head pipe0", s0v, 0); check("R5 blocked head pipe1", s1v, 0);
      idle(); idle(); check("R5 still blocked", s0v, 0);
      idle();
      check("R5 release pipe0", s0t, 12); check("R5 release pipe1 tag", s1t, 13);
      retire_n(7);

      // same destination
      cyc(1, mk(14,0,1,1,7,9,8), 1, mk(15,0,1,1,7,11,10), 0, 0);
      idle(); check("R3 older alone", s0t, 14); check("R3 younger held", s1v, 0);
      idle(); check("R3 younger next", s0t, 15);

      // shared resource
      cyc(1, mk(16,1,1,0,0,9,8), 1, mk(17,1,1,0,0,11,10), 0, 0);
      idle(); check("R4 older alone", s0t, 16); check("R4 younger held", s1v, 0);
      idle(); check("R4 younger next", s0t, 17);
      retire_n(4);
      retire_n(2); // nothing in flight: must be ignored (R10)

      // replay after partial retire
      cyc(1, mk(20,0,1,0,0,9,8), 1, mk(21,0,1,0,0,11,10), 0, 0);
      idle(); check("R8 pair before replay", s1t, 21);
      retire_n(1);
      exp_q.push_back(8'd21);
      cyc(1, mk(22,0,1,0,0,13,12), 0, '0, 1, 0);
      check("R8 quiet in replay cycle", s0v, 0);
      idle();
      check("R8 reissue oldest unretired", s0t, 21);
      check("R10 spare retires ignored", s1v, 1);
      check("R8 newcomer follows", s1t, 22);
      retire_n(2);

      // replay clears countdowns
      cyc(1, mk(23,0,7,1,1,9,8), 0, '0, 0, 0);
      idle(); check("R9 long producer", s0t, 23);
      retire_n(1);
      cyc(1, mk(24,0,1,0,0,10,1), 0, '0, 1, 0);
      idle(); check("R9 consumer ready after replay", s0v, 1); check("R9 consumer tag", s0t, 24);
      retire_n(1);

      // capacity
      for (int p = 0; p < 4; p++) begin
         cyc(1, mk(25 + 2*p,0,1,0,0,9,8), 1, mk(26 + 2*p,0,1,0,0,11,10), 0, 0);
         check("R11 ready while room", srdy, 1);
      end
      idle(); check("R11 full not ready", srdy, 0);
      cyc(1, mk(33,0,1,0,0,9,8), 1, mk(34,0,1,0,0,11,10), 0, 0);
      idle(); check("R11 offered pair not taken", s0v, 0);
      retire_n(8);
      idle(); check("R11 ready after drain", srdy, 1);

      idle(); idle();
      check("R1 all expected issued", exp_q.size(), 0);
      finish_run();
   end
endmodule